// File: doc/BRIEF.md
# Shadowed Register Bank with Commit Strobe

This block is the register storage that sits behind a serial control port. Every writable register is held twice. A write from the port changes only the staging copy, called the shadow. The copy that drives the core, called the live copy, stays as it was. Software can stage any number of register writes across many transactions. It then writes a 1 to bit 0 of the control register at address 0x05. On the next clock, every shadow value is copied into the live registers at the same moment, so the core never sees a half-updated configuration.

The bank also holds read-only status registers. These are not buffered: a read returns the core's status input as it is at that moment, and writes to them are dropped. A small address decoder places the control register, a window of writable configuration registers and a window of status registers in the map. Any other address reads as zero and ignores writes.

The serial port drives the block through two ports:
- a byte-wide synchronous write port;
- a read port whose data appears one clock after the request.

Top module: `shadow_regbank`

## Requirements
- R1: While `rst_n` is low, and after it is released, every shadow and live register holds its default value: configuration register i (address 0x10+i) defaults to byte i of `RW_DEFAULTS` (0x11, 0x22, 0x33, 0x44 at defaults), and control bits [7:1] default to 0.
- R2: A write to configuration address 0x10..0x13 changes only that register's shadow. `cfg_live` and `ctrl_live` keep their values until a commit.
- R3: A read of a configuration address returns that register's shadow value. `rd_data` is valid in the cycle after the `rd_en` clock edge.
- R4: A write to address 0x05 with data bit 0 = 1, taken at clock edge k, copies every shadow into its live register at edge k+1, all in the same edge. A shadow write taken at edge k+1 is not part of that commit.
- R5: Several shadow writes staged before one update are all made live by that single commit.
- R6: The update bit clears itself. A read of 0x05 returns 0 in bit 0, and a later shadow write does not reach the live copy without a new update.
- R7: In a byte written to 0x05 with bit 0 = 1, bits [7:1] are first captured into the control shadow and are then included in the commit that the same write starts. They appear on `ctrl_live` at edge k+1.
- R8: A read of status address 0x20+j returns byte j of `sts_in` as sampled at the read edge. Writes to status addresses have no effect.
- R9: Addresses outside 0x05, 0x10..0x13 and 0x20..0x21 read as 0x00, and writes to them change no register.
- R10: A write to 0x05 with bit 0 = 0 updates the control shadow (readable as bits [7:1] of 0x05) without starting a commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe from the serial port |
| wr_addr | input | ADDR_W (8) | Write address |
| wr_data | input | DATA_W (8) | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (8) | Read address |
| rd_data | output | DATA_W (8) | Read data, registered |
| sts_in | input | NUM_RO*DATA_W (16) | Status bytes from the core, byte j at [8j+7:8j] |
| cfg_live | output | NUM_RW*DATA_W (32) | Live configuration bytes, register i at [8i+7:8i] |
| ctrl_live | output | DATA_W-1 (7) | Live control bits [7:1] of address 0x05 |

## Verification
The bound checker checks the following on every cycle:
- the live outputs stay stable whenever no commit is in progress;
- the shadow changes only under a write strobe;
- two cycles after an update write, the live image equals the shadow as it stood one cycle after that write;
- the control bits written with the update go live;
- reads of 0x05 return 0 in bit 0;
- status reads and unmapped reads return the expected values.

Other behaviour depends on a sequence of operations, and only the bench's scenarios can show it:
- several writes accumulate and are committed by one update;
- no further commit happens once the update bit has cleared;
- a shadow write in the commit cycle is left out of that commit;
- a reset in mid-run restores every default.

// File: rtl/srb_pkg.sv
`timescale 1ns/1ps
package srb_pkg;
   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_CTRL = 2'd1,
      HIT_RW   = 2'd2,
      HIT_RO   = 2'd3
   } hit_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/regbank_decode.sv
`timescale 1ns/1ps
module regbank_decode
   import srb_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int CTRL_ADDR = 5,
   parameter int RW_BASE   = 16,
   parameter int NUM_RW    = 4,
   parameter int RO_BASE   = 32,
   parameter int NUM_RO    = 2,
   parameter int RW_IDX_W  = 2,
   parameter int RO_IDX_W  = 1
) (
   input  logic [ADDR_W-1:0]   addr,
   output hit_e                kind,
   output logic [RW_IDX_W-1:0] rw_idx,
   output logic [RO_IDX_W-1:0] ro_idx
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] RW_LO  = ADDR_W'(RW_BASE);
   localparam logic [ADDR_W-1:0] RW_HI  = ADDR_W'(RW_BASE + NUM_RW - 1);
   localparam logic [ADDR_W-1:0] RO_LO  = ADDR_W'(RO_BASE);
   localparam logic [ADDR_W-1:0] RO_HI  = ADDR_W'(RO_BASE + NUM_RO - 1);

   logic [ADDR_W-1:0] rw_off;
   logic [ADDR_W-1:0] ro_off;

   assign rw_off = addr - RW_LO;
   assign ro_off = addr - RO_LO;

   always_comb begin
      kind   = HIT_NONE;
      rw_idx = rw_off[RW_IDX_W-1:0];
      ro_idx = ro_off[RO_IDX_W-1:0];
      if (addr == CTRL_A) begin
         kind = HIT_CTRL;
      end else if (addr >= RW_LO && addr <= RW_HI) begin
         kind = HIT_RW;
      end else if (addr >= RO_LO && addr <= RO_HI) begin
         kind = HIT_RO;
      end
   end
endmodule

// File: rtl/regbank_cell.sv
`timescale 1ns/1ps
module regbank_cell #(
   parameter int            W   = 8,
   parameter logic [W-1:0]  RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_stb,
   input  logic [W-1:0] wr_val,
   input  logic         commit,
   output logic [W-1:0] shadow_q,
   output logic [W-1:0] live_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= RST;
      end else if (wr_stb) begin
         shadow_q <= wr_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= RST;
      end else if (commit) begin
         live_q <= shadow_q;
      end
   end
endmodule

// File: rtl/shadow_regbank.sv
`timescale 1ns/1ps
module shadow_regbank
   import srb_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 5,
   parameter int RW_BASE   = 16,
   parameter int NUM_RW    = 4,
   parameter int RO_BASE   = 32,
   parameter int NUM_RO    = 2,
   parameter logic [NUM_RW*DATA_W-1:0] RW_DEFAULTS  = (NUM_RW*DATA_W)'('h44332211),
   parameter logic [DATA_W-2:0]        CTRL_DEFAULT = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   input  logic [NUM_RO*DATA_W-1:0] sts_in,
   output logic [NUM_RW*DATA_W-1:0] cfg_live,
   output logic [DATA_W-2:0]        ctrl_live
);
   localparam int RW_IDX_W = idx_width(NUM_RW);
   localparam int RO_IDX_W = idx_width(NUM_RO);

   // elaboration-time parameter checks
   if (NUM_RW < 1 || NUM_RO < 1) begin : g_bad_count
      $error("shadow_regbank: NUM_RW and NUM_RO must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("shadow_regbank: DATA_W must be at least 2");
   end
   if (RW_BASE + NUM_RW > (1 << ADDR_W) || RO_BASE + NUM_RO > (1 << ADDR_W)) begin : g_bad_map
      $error("shadow_regbank: register window exceeds address space");
   end
   if ((CTRL_ADDR >= RW_BASE && CTRL_ADDR < RW_BASE + NUM_RW) ||
       (CTRL_ADDR >= RO_BASE && CTRL_ADDR < RO_BASE + NUM_RO) ||
       (RW_BASE < RO_BASE + NUM_RO && RO_BASE < RW_BASE + NUM_RW)) begin : g_bad_overlap
      $error("shadow_regbank: address windows overlap");
   end

   hit_e                wr_kind;
   logic [RW_IDX_W-1:0] wr_rw_idx;
   logic [RO_IDX_W-1:0] wr_ro_idx;
   hit_e                rd_kind;
   logic [RW_IDX_W-1:0] rd_rw_idx;
   logic [RO_IDX_W-1:0] rd_ro_idx;

   regbank_decode #(
      .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RW_BASE(RW_BASE), .NUM_RW(NUM_RW),
      .RO_BASE(RO_BASE), .NUM_RO(NUM_RO), .RW_IDX_W(RW_IDX_W), .RO_IDX_W(RO_IDX_W)
   ) u_wr_dec (
      .addr(wr_addr), .kind(wr_kind), .rw_idx(wr_rw_idx), .ro_idx(wr_ro_idx)
   );

   regbank_decode #(
      .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RW_BASE(RW_BASE), .NUM_RW(NUM_RW),
      .RO_BASE(RO_BASE), .NUM_RO(NUM_RO), .RW_IDX_W(RW_IDX_W), .RO_IDX_W(RO_IDX_W)
   ) u_rd_dec (
      .addr(rd_addr), .kind(rd_kind), .rw_idx(rd_rw_idx), .ro_idx(rd_ro_idx)
   );

   // write side: the update bit is a one-cycle pulse, never stored
   logic commit_q;
   logic ctrl_wr;
   logic ro_wr_unused;

   assign ctrl_wr      = wr_en && (wr_kind == HIT_CTRL);
   assign ro_wr_unused = ^wr_ro_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_q <= 1'b0;
      end else begin
         commit_q <= ctrl_wr && wr_data[0];
      end
   end

   logic [DATA_W-1:0]        cfg_shadow [NUM_RW];
   logic [NUM_RW*DATA_W-1:0] cfg_shadow_flat;
   logic [DATA_W-2:0]        ctrl_shadow;

   for (genvar i = 0; i < NUM_RW; i++) begin : g_cfg
      logic hit_i;
      assign hit_i = wr_en && (wr_kind == HIT_RW) && (wr_rw_idx == RW_IDX_W'(i));
      regbank_cell #(
         .W(DATA_W), .RST(RW_DEFAULTS[i*DATA_W +: DATA_W])
      ) u_cell (
         .clk(clk), .rst_n(rst_n), .wr_stb(hit_i), .wr_val(wr_data),
         .commit(commit_q), .shadow_q(cfg_shadow[i]),
         .live_q(cfg_live[i*DATA_W +: DATA_W])
      );
      assign cfg_shadow_flat[i*DATA_W +: DATA_W] = cfg_shadow[i];
   end

   regbank_cell #(
      .W(DATA_W-1), .RST(CTRL_DEFAULT)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_stb(ctrl_wr), .wr_val(wr_data[DATA_W-1:1]),
      .commit(commit_q), .shadow_q(ctrl_shadow), .live_q(ctrl_live)
   );

   // read side
   logic [DATA_W-1:0] sts_byte [NUM_RO];
   for (genvar j = 0; j < NUM_RO; j++) begin : g_sts
      assign sts_byte[j] = sts_in[j*DATA_W +: DATA_W];
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      unique case (rd_kind)
         HIT_CTRL: rd_mux = {ctrl_shadow, 1'b0};
         HIT_RW:   rd_mux = cfg_shadow[rd_rw_idx];
         HIT_RO:   rd_mux = sts_byte[rd_ro_idx];
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= rd_mux;
      end
   end
endmodule

// File: rtl/shadow_regbank_chk.sv
`timescale 1ns/1ps
module shadow_regbank_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 5,
   parameter int RW_BASE   = 16,
   parameter int NUM_RW    = 4,
   parameter int RO_BASE   = 32,
   parameter int NUM_RO    = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic [DATA_W-1:0]        wr_data,
   input logic                     rd_en,
   input logic [ADDR_W-1:0]        rd_addr,
   input logic [DATA_W-1:0]        rd_data,
   input logic [NUM_RO*DATA_W-1:0] sts_in,
   input logic [NUM_RW*DATA_W-1:0] cfg_live,
   input logic [DATA_W-2:0]        ctrl_live,
   input logic [NUM_RW*DATA_W-1:0] cfg_shadow_flat,
   input logic                     commit
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] RO_A0  = ADDR_W'(RO_BASE);

   logic upd_wr;
   logic rd_unmapped;
   assign upd_wr = wr_en && (wr_addr == CTRL_A) && wr_data[0];
   assign rd_unmapped = (int'(rd_addr) != CTRL_ADDR) &&
                        !(int'(rd_addr) >= RW_BASE && int'(rd_addr) < RW_BASE + NUM_RW) &&
                        !(int'(rd_addr) >= RO_BASE && int'(rd_addr) < RO_BASE + NUM_RO);

   // R2: live copies move only in a commit cycle
   p_live_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(cfg_live) && $stable(ctrl_live)));

   // R2: shadow copies move only under a write strobe
   p_shadow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_shadow_flat));

   // R4: two edges after an update write the live image equals the staged image
   p_commit_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      upd_wr |-> ##2 (cfg_live == $past(cfg_shadow_flat)));

   // R7: control bits written alongside the update go live with it
   p_ctrl_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      upd_wr |-> ##2 (ctrl_live == $past(wr_data[DATA_W-1:1], 2)));

   // R6: update bit always reads as zero
   p_upd_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == CTRL_A) |=> !rd_data[0]);

   // R8: first status register reads the status input
   p_status_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == RO_A0) |=> (rd_data == $past(sts_in[DATA_W-1:0])));

   // R9: unmapped reads return zero
   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_unmapped) |=> (rd_data == '0));
endmodule

bind shadow_regbank shadow_regbank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .RW_BASE(RW_BASE),
   .NUM_RW(NUM_RW), .RO_BASE(RO_BASE), .NUM_RO(NUM_RO)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sts_in(sts_in),
   .cfg_live(cfg_live), .ctrl_live(ctrl_live), .cfg_shadow_flat(cfg_shadow_flat),
   .commit(commit_q)
);

// File: tb/shadow_regbank_tb_top.sv
`timescale 1ns/1ps
module shadow_regbank_tb_top;
   localparam logic [1:0] OP_W = 2'd0;  // write
   localparam logic [1:0] OP_R = 2'd1;  // read and compare rd_data
   localparam logic [1:0] OP_L = 2'd2;  // compare live byte (0..3 cfg, 4 ctrl)
   localparam logic [1:0] OP_I = 2'd3;  // idle
   localparam int NV = 33;

   // {op, addr, data, expected, requirement number}
   localparam logic [29:0] VEC [NV] = '{
      {OP_R, 8'h10, 8'h00, 8'h11, 4'd1},   // R1 default
      {OP_R, 8'h13, 8'h00, 8'h44, 4'd1},   // R1 default
      {OP_W, 8'h10, 8'hA0, 8'h00, 4'd2},
      {OP_W, 8'h12, 8'hB2, 8'h00, 4'd2},
      {OP_R, 8'h10, 8'h00, 8'hA0, 4'd3},   // R3 shadow read
      {OP_L, 8'd0,  8'h00, 8'h11, 4'd2},   // R2 live unchanged
      {OP_L, 8'd2,  8'h00, 8'h33, 4'd2},   // R2
      {OP_W, 8'h05, 8'h01, 8'h00, 4'd4},   // update
      {OP_I, 8'h00, 8'h00, 8'h00, 4'd4},
      {OP_L, 8'd0,  8'h00, 8'hA0, 4'd4},   // R4 committed
      {OP_L, 8'd2,  8'h00, 8'hB2, 4'd5},   // R5 both staged writes
      {OP_L, 8'd1,  8'h00, 8'h22, 4'd4},   // R4 untouched reg
      {OP_R, 8'h05, 8'h00, 8'h00, 4'd6},   // R6 reads zero
      {OP_W, 8'h11, 8'hC1, 8'h00, 4'd6},
      {OP_I, 8'h00, 8'h00, 8'h00, 4'd6},
      {OP_I, 8'h00, 8'h00, 8'h00, 4'd6},
      {OP_L, 8'd1,  8'h00, 8'h22, 4'd6},   // R6 no further commit
      {OP_W, 8'h05, 8'hFB, 8'h00, 4'd7},
      {OP_I, 8'h00, 8'h00, 8'h00, 4'd7},
      {OP_L, 8'd4,  8'h00, 8'h7D, 4'd7},   // R7 ctrl bits go live
      {OP_L, 8'd1,  8'h00, 8'hC1, 4'd5},   // R5
      {OP_R, 8'h05, 8'h00, 8'hFA, 4'd6},   // R6 bit0 clear
      {OP_W, 8'h05, 8'h06, 8'h00, 4'd10},
      {OP_I, 8'h00, 8'h00, 8'h00, 4'd10},
      {OP_L, 8'd4,  8'h00, 8'h7D, 4'd10},  // R10 no commit
      {OP_R, 8'h05, 8'h00, 8'h06, 4'd10},  // R10 shadow updated
      {OP_W, 8'h20, 8'hFF, 8'h00, 4'd8},
      {OP_R, 8'h20, 8'h00, 8'h5A, 4'd8},   // R8
      {OP_R, 8'h21, 8'h00, 8'hC3, 4'd8},   // R8
      {OP_W, 8'h30, 8'h77, 8'h00, 4'd9},
      {OP_R, 8'h30, 8'h00, 8'h00, 4'd9},   // R9
      {OP_R, 8'h07, 8'h00, 8'h00, 4'd9},   // R9
      {OP_L, 8'd0,  8'h00, 8'hA0, 4'd9}    // R9 no register touched
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic [15:0] sts_in = 16'hC35A;
   logic [31:0] cfg_live;
   logic [6:0]  ctrl_live;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   shadow_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sts_in(sts_in),
      .cfg_live(cfg_live), .ctrl_live(ctrl_live)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] live_byte(input int idx);
      if (idx == 4) return {1'b0, ctrl_live};
      return cfg_live[idx*8 +: 8];
   endfunction

   // one operation per clock: drive at negedge, results read 1 ns after the edge
   task automatic op(input logic [1:0] kind, input logic [7:0] a, input logic [7:0] d,
                     input logic [7:0] exp, input string req);
      @(negedge clk);
      wr_en = (kind == OP_W); wr_addr = a; wr_data = d;
      rd_en = (kind == OP_R); rd_addr = a;
      if (kind == OP_L) check(req, live_byte(int'(a)), exp);
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_en = 1'b0;
      if (kind == OP_R) check(req, rd_data, exp);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: defaults visible during reset
      check("R1", cfg_live[7:0], 8'h11);
      check("R1", cfg_live[31:24], 8'h44);
      check("R1", {1'b0, ctrl_live}, 8'h00);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         op(VEC[v][29:28], VEC[v][27:20], VEC[v][19:12], VEC[v][11:4],
            $sformatf("R%0d", VEC[v][3:0]));
      end

      // R4: a shadow write in the commit cycle is left out of that commit
      op(OP_W, 8'h13, 8'h55, 8'h00, "R4");
      op(OP_W, 8'h05, 8'h01, 8'h00, "R4");
      op(OP_W, 8'h13, 8'h66, 8'h00, "R4");
      op(OP_I, 8'h00, 8'h00, 8'h00, "R4");
      op(OP_L, 8'd3,  8'h00, 8'h55, "R4");
      op(OP_R, 8'h13, 8'h00, 8'h66, "R4");

      // R8: status read follows a changed input
      sts_in = 16'h0F96;
      op(OP_R, 8'h20, 8'h00, 8'h96, "R8");

      // R1: reset in mid-run restores every default
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", cfg_live[7:0], 8'h11);
      check("R1", cfg_live[31:24], 8'h44);
      check("R1", {1'b0, ctrl_live}, 8'h00);
      rst_n = 1'b1;
      op(OP_R, 8'h13, 8'h00, 8'h44, "R1");
      op(OP_R, 8'h05, 8'h00, 8'h00, "R1");

      finish_run();
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end
endmodule